// File: doc/BRIEF.md
# Double-Edge Serial-to-Word Receiver

This block rebuilds parallel words from a set of pins that each carry two bits per cycle of a clock forwarded by the sending device. Every pin is sampled on both edges of that clock. The rising-edge sample and the falling-edge sample go to two separate shift registers, one for even-numbered bits and one for odd-numbered bits. Once a whole word's worth of bit pairs has arrived, the two registers are interleaved into one word. That word is loaded into an output register that updates once per word period, which is one quarter of the forwarded clock rate for 8-bit words.

The word period is counted by a phase counter that starts at reset. A synchronous alignment input restarts the counter at any bit pair, so the receiver can be locked to the sender's word boundary. In the full interface this channel is repeated across the data and control pins of each direction. One instance covers `CH` pins that share a clock, with each pin rebuilding its own word in its own slice of the output.

Top module: `ddr_des_rx`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `valid_o` is 0 and `word_o` is all zeros after that edge.
- R2: On each pin, the value sampled at a rising edge of `clk` becomes an even-numbered bit of the word (bit 2i), and the value sampled at the following falling edge becomes the odd-numbered bit just above it (bit 2i+1).
- R3: The first bit pair of a word lands in bits 1:0, and each later pair lands in the next higher two bits. With 8-bit words, the fourth pair lands in bits 7:6.
- R4: While bit pairs stream without alignment events, `valid_o` is high for exactly one cycle in every `WORD_W/2` cycles, and every word that was sent arrives, in order.
- R5: After reset is released, the first rising edge samples the even bit of pair 0. The first `valid_o` pulse becomes visible after rising edge number `WORD_W/2` (counting the first edge after release as edge 0), which is `WORD_W/2+1` rising edges after release.
- R6: When `align_i` is high at a rising edge, the bit pair completed just before that edge becomes pair 0 of a new word. Partly assembled pairs are dropped, `valid_o` is low after that edge, and the next word appears `WORD_W/2-1` rising edges later.
- R7: Pin c rebuilds its word only from its own input `din_i[c]`, and that word appears in `word_o[c*WORD_W +: WORD_W]`.
- R8: `word_o` changes only at the edge that also raises `valid_o`. In every other cycle it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forwarded capture clock; both edges sample data |
| rst | input | 1 | Synchronous active-high reset |
| align_i | input | 1 | Marks the pair finished just before this rising edge as the first pair of a word |
| din_i | input | CH | Double-rate serial data, one bit per pin |
| word_o | output | CH*WORD_W | Rebuilt words, pin c in slice c |
| valid_o | output | 1 | One-cycle strobe: `word_o` was loaded at this edge |

## Verification
The assertions assume that `din_i` is stable around both clock edges and that the sender keeps supplying a bit pair every cycle once reset is released. They also assume `align_i` is a single-cycle pulse that is never raised on the edge where a word would finish. The bench's sender model changes data only a quarter period after each edge, and it never leaves a gap in the pair stream. It raises the alignment pulse only at the edge that follows the first pair of a chosen word. Near-exhaustive sweeps of every 8-bit value on one pin, with a related pattern on the other pin, exercise bit placement. Runs of zero, two and three stray pairs before an alignment test each restart phase.

// File: rtl/ddr_des_pkg.sv
package ddr_des_pkg;

  // per-edge control derived from the word-phase counter
  typedef struct packed {
    logic shift;    // a complete bit pair is held in the capture stage
    logic emit;     // this shift finishes a word
    logic restart;  // this shift starts a new word
  } phase_ctrl_t;

endpackage

// File: rtl/ddr_des_capture.sv
module ddr_des_capture #(
  parameter int unsigned CH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CH-1:0] din_i,
  output logic [CH-1:0] rise_o,
  output logic [CH-1:0] fall_o
);

  // rising edge: even bit of the pair
  always_ff @(posedge clk) begin
    if (rst) rise_o <= '0;
    else     rise_o <= din_i;
  end

  // falling edge: odd bit of the pair
  always_ff @(negedge clk) begin
    if (rst) fall_o <= '0;
    else     fall_o <= din_i;
  end

endmodule

// File: rtl/ddr_des_phase.sv
module ddr_des_phase
  import ddr_des_pkg::*;
#(
  parameter int unsigned PAIRS = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        align_i,
  output phase_ctrl_t ctrl_o
);

  localparam int unsigned CW = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PAIRS - 1);

  logic          primed_q;
  logic [CW-1:0] cnt_q;

  // the first rising edge after reset only fills the capture stage
  always_ff @(posedge clk) begin
    if (rst) primed_q <= 1'b0;
    else     primed_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (primed_q) begin
      if (align_i)            cnt_q <= CW'(1);
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + CW'(1);
    end
  end

  always_comb begin
    ctrl_o.shift   = primed_q;
    ctrl_o.restart = primed_q && align_i;
    ctrl_o.emit    = primed_q && !align_i && (cnt_q == LAST);
  end

endmodule

// File: rtl/ddr_des_lane.sv
module ddr_des_lane #(
  parameter int unsigned PAIRS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_i,
  input  logic               rise_i,
  input  logic               fall_i,
  output logic [2*PAIRS-1:0] word_nx_o
);

  logic [PAIRS-1:0] even_q, odd_q;
  logic [PAIRS-1:0] even_nx, odd_nx;
  logic [PAIRS:0]   even_cat, odd_cat;

  // newest pair enters at the top, so the first pair ends at index 0
  always_comb begin
    even_cat = {rise_i, even_q};
    odd_cat  = {fall_i, odd_q};
    even_nx  = even_cat[PAIRS:1];
    odd_nx   = odd_cat[PAIRS:1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      even_q <= '0;
      odd_q  <= '0;
    end else if (shift_i) begin
      even_q <= even_nx;
      odd_q  <= odd_nx;
    end
  end

  for (genvar i = 0; i < PAIRS; i++) begin : g_merge
    assign word_nx_o[2*i]   = even_nx[i];
    assign word_nx_o[2*i+1] = odd_nx[i];
  end

endmodule

// File: rtl/ddr_des_rx.sv
module ddr_des_rx
  import ddr_des_pkg::*;
#(
  parameter int unsigned CH     = 2,
  parameter int unsigned WORD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 align_i,
  input  logic [CH-1:0]        din_i,
  output logic [CH*WORD_W-1:0] word_o,
  output logic                 valid_o
);

  localparam int unsigned PAIRS = WORD_W / 2;

  logic [CH-1:0]        rise_s, fall_s;
  logic [CH*WORD_W-1:0] word_nx;
  phase_ctrl_t          ctrl;

  ddr_des_capture #(.CH(CH)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .din_i  (din_i),
    .rise_o (rise_s),
    .fall_o (fall_s)
  );

  ddr_des_phase #(.PAIRS(PAIRS)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .align_i (align_i),
    .ctrl_o  (ctrl)
  );

  for (genvar c = 0; c < CH; c++) begin : g_pin
    ddr_des_lane #(.PAIRS(PAIRS)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .shift_i   (ctrl.shift),
      .rise_i    (rise_s[c]),
      .fall_i    (fall_s[c]),
      .word_nx_o (word_nx[c*WORD_W +: WORD_W])
    );
  end

  // word-rate output register, enabled once per word period
  always_ff @(posedge clk) begin
    if (rst) begin
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= ctrl.emit;
      if (ctrl.emit) word_o <= word_nx;
    end
  end

endmodule

// File: rtl/ddr_des_rx_chk.sv
module ddr_des_rx_chk #(
  parameter int unsigned CH     = 2,
  parameter int unsigned WORD_W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 align_i,
  input logic [CH*WORD_W-1:0] word_o,
  input logic                 valid_o
);

  localparam int unsigned PAIRS = WORD_W / 2;
  localparam int unsigned GW    = $clog2(PAIRS + 2) + 1;
  localparam logic [GW-1:0] GMAX = {GW{1'b1}};
  localparam logic [GW-1:0] FIRST = GW'(PAIRS + 1);

  logic [GW-1:0] since_q, gap_q;
  logic          had_prev_q, al_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q    <= '0;
      gap_q      <= '0;
      had_prev_q <= 1'b0;
      al_seen_q  <= 1'b0;
    end else begin
      if (since_q != GMAX) since_q <= since_q + GW'(1);
      if (valid_o)             gap_q <= GW'(1);
      else if (gap_q != GMAX)  gap_q <= gap_q + GW'(1);
      if (valid_o) had_prev_q <= 1'b1;
      al_seen_q <= valid_o ? align_i : (al_seen_q | align_i);
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!valid_o && word_o == '0));

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  p_word_period_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_o && had_prev_q && !al_seen_q) |-> (gap_q == GW'(PAIRS)));

  p_first_word_r5: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (since_q >= FIRST));

  p_align_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    align_i |=> !valid_o);

  p_word_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(word_o));

endmodule

bind ddr_des_rx ddr_des_rx_chk #(.CH(CH), .WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .align_i (align_i),
  .word_o  (word_o),
  .valid_o (valid_o)
);

// File: tb/test_ddr_des_rx.sv
module test_ddr_des_rx;

  localparam int CH = 2;
  localparam int W  = 8;
  localparam int P  = W / 2;
  localparam int QN = 512;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            align_i = 1'b0;
  logic [CH-1:0]   din_i = '0;
  logic [CH*W-1:0] word_o;
  logic            valid_o;

  always #10 clk = ~clk;

  ddr_des_rx #(.CH(CH), .WORD_W(W)) i_ddr_des_rx (
    .clk(clk), .rst(rst), .align_i(align_i), .din_i(din_i),
    .word_o(word_o), .valid_o(valid_o)
  );

  int total = 0, bad = 0;
  logic [CH*W-1:0] exp_w [QN];
  logic            exp_c [QN];
  string           exp_t [QN];
  int wr = 0, rd = 0;
  logic pend_al = 1'b0;
  logic monitor_on = 1'b0;
  logic finished = 1'b0;
  int edges = 0;
  int ngap = 0;
  logic seen_first = 1'b0;
  logic [CH*W-1:0] last_w = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // rising edges counted from reset release (edge 0 = first one after release)
  always @(posedge clk) begin
    if (rst) edges = 0;
    else     edges++;
  end

  // output monitor, half a period away from the sampling edge
  always @(negedge clk) begin
    if (monitor_on) begin
      ngap++;
      if (valid_o) begin
        if (!seen_first) begin
          check(edges == P + 1, "R5", "first word edge", edges, P + 1);
          seen_first = 1'b1;
        end else if (rd < wr && exp_c[rd]) begin
          check(ngap == P, "R4", "word period", ngap, P);
        end
        if (rd < wr) begin
          check(word_o == exp_w[rd], exp_t[rd], "word", word_o, exp_w[rd]);
          rd++;
        end else begin
          check(1'b0, "R4", "unexpected word", word_o, 0);
        end
        last_w = word_o;
        ngap = 0;
      end else begin
        check(word_o == last_w, "R8", "hold", word_o, last_w);
      end
    end
  end

  // sender model: even bit a quarter period before the rising edge,
  // odd bit a quarter period before the falling edge
  task automatic send_pair(input logic [CH-1:0] ev, input logic [CH-1:0] od,
                           input logic al);
    @(negedge clk); #5;
    rst = 1'b0;
    monitor_on = 1'b1;
    din_i = ev;
    align_i = al;
    @(posedge clk); #5;
    din_i = od;
    align_i = 1'b0;
  endtask

  task automatic send_word(input logic [CH*W-1:0] w, input logic al,
                           input logic contig, input string tag);
    exp_w[wr] = w; exp_c[wr] = contig; exp_t[wr] = tag; wr++;
    for (int p = 0; p < P; p++) begin
      logic [CH-1:0] ev, od;
      for (int c = 0; c < CH; c++) begin
        ev[c] = w[c*W + 2*p];
        od[c] = w[c*W + 2*p + 1];
      end
      send_pair(ev, od, pend_al);
      pend_al = (p == 0) && al;
    end
  endtask

  task automatic stray_pairs(input int n);
    for (int k = 0; k < n; k++) begin
      send_pair(CH'($urandom), CH'($urandom), pend_al);
      pend_al = 1'b0;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #2;
    // R1: outputs cleared during reset
    check(valid_o == 1'b0, "R1", "valid in reset", valid_o, 0);
    check(word_o == '0, "R1", "word in reset", word_o, 0);

    // R3: first pair at bits 1:0, last pair at 7:6
    send_word({8'h80, 8'h01}, 1'b0, 1'b1, "R3");
    send_word({8'h40, 8'h02}, 1'b0, 1'b1, "R3");
    // R2: rising samples only on pin 0, falling samples only on pin 1
    send_word({8'hAA, 8'h55}, 1'b0, 1'b1, "R2");
    // R7: pins kept apart
    send_word({8'hFF, 8'h00}, 1'b0, 1'b1, "R7");
    send_word({8'h00, 8'hFF}, 1'b0, 1'b1, "R7");

    // R4: every byte value on pin 0, a scrambled partner on pin 1
    for (int v = 0; v < 256; v++)
      send_word({8'(v) ^ 8'hA5, 8'(v)}, 1'b0, 1'b1, "R4");

    // R6: realign after 0, 2 and 3 stray pairs
    for (int s = 0; s < 4; s++) begin
      if (s == 1) continue;
      stray_pairs(s);
      send_word({8'(16'h3C00 >> s), 8'(8'hC3 + s)}, 1'b1, (s == 0), "R6");
      for (int k = 0; k < 3; k++)
        send_word({CH{8'($urandom)}}, 1'b0, 1'b1, "R6");
    end

    // flush: one more pair so the last word completes, then stop watching
    send_pair('0, '0, pend_al);
    repeat (2) @(negedge clk);
    #1;
    monitor_on = 1'b0;
    check(rd == wr, "R4", "words received", rd, wr);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

endmodule